// File: doc/BRIEF.md
# Rank-Clustering Read-First Command Reorderer

This block rearranges the commands that have collected in a memory controller's blocked request queue at the moment the throttle window expires, before any of them are forwarded to the per-rank command queues. Software or upstream logic writes the pending commands into an indexed entry store. Each entry holds a target rank, a read/write flag, an address and an arrival tag. It then gives the number of valid entries and pulses `start`. The block places every command for one rank into one contiguous set. The sets are ordered by the arrival position of each rank's earliest command. Inside a set, reads are moved ahead of writes so that the latency-critical accesses reach their rank first.

A read is never moved past an older write to the same address. Such a read stays in the write group at its arrival position, which keeps read-after-write order intact. When the run completes, `done` rises. The reordered sequence can then be read slot by slot, and a per-rank read count and write count is presented for the throttle logic. That logic decides which ranks to wake. The work is sequential. One pass tallies one entry per cycle, then one cycle computes the set base offsets, and a second pass moves one entry per cycle into the output store.

Top module: `rank_cluster_reorder`

## Requirements
- R1: While and after synchronous reset, `busy` and `done` are low and every per-rank count is zero.
- R2: A `start` pulse while not busy makes `busy` high and `done` low on the next cycle. `done` rises when the run ends and stays high, with `busy` low, until the next accepted `start`. `busy` and `done` are never high together.
- R3: In the output sequence, all commands with the same rank occupy adjacent slots.
- R4: The rank sets appear in the order in which each rank's first command arrived (lowest entry index).
- R5: Within a set, reads that have no older same-address write in that set come first, in arrival order. All other commands of the set follow in arrival order. Output slot p holds the p-th command of this sequence.
- R6: No read ends up ahead of an older write to the same address. An address always belongs to a single rank.
- R7: After `done`, field r of `set_reads` (bits r*CNTW upward, CNTW bits wide) holds the number of reads for rank r, and the same field of `set_writes` holds its writes. Together they sum to the number of processed entries.
- R8: Entry loads and `start` pulses that arrive while `busy` is high have no effect on the run or on the stored entries it uses.
- R9: `num_cmds` of zero completes a run with all counts zero. A `num_cmds` above DEPTH is treated as DEPTH.
- R10: The output read port has one cycle of latency. `rd_*` show the slot selected by `rd_idx` at the preceding clock edge.
- R11: Each processed entry appears exactly once in the output sequence, with its fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one entry into the input store |
| ld_idx | input | IDXW | Entry slot to write (arrival position) |
| ld_rank | input | RANKW | Target rank of the entry |
| ld_is_wr | input | 1 | 1 = write, 0 = read |
| ld_addr | input | ADDR_W | Access address |
| ld_seq | input | SEQ_W | Arrival tag carried through unchanged |
| num_cmds | input | CNTW | Number of valid entries, sampled at start |
| start | input | 1 | Begin a reorder run (ignored while busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| rd_idx | input | IDXW | Output slot to read |
| rd_rank | output | RANKW | Rank of the selected output slot |
| rd_is_wr | output | 1 | Type of the selected output slot |
| rd_addr | output | ADDR_W | Address of the selected output slot |
| rd_seq | output | SEQ_W | Arrival tag of the selected output slot |
| set_reads | output | NRANK*CNTW | Per-rank read counts, one CNTW field per rank |
| set_writes | output | NRANK*CNTW | Per-rank write counts, one CNTW field per rank |

## Verification
A wrong set base offset or a wrong cursor shows up at the ports only after `done`. It appears as two entries written to the same output slot, so one arrival tag is missing and another is duplicated, or as a rank set that is split or out of order. Reading back every slot of each run therefore exposes it within the same run. A bad hazard flag reveals itself as a read placed before an older same-address write, and a tally fault shows directly in the per-rank counts once `done` rises. Stimulus mixes random queues, dense in same-address pairs, with a directed four-rank case, a hazard chain, an empty run, an over-length count, and loads and starts issued in the middle of a run.

// File: rtl/rcq_pkg.sv
package rcq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SCAN,
    PH_BASE,
    PH_PLACE,
    PH_DONE
  } rcq_phase_e;
endpackage

// File: rtl/rcq_src_store.sv
module rcq_src_store #(
  parameter int DEPTH  = 16,
  parameter int NRANK  = 4,
  parameter int ADDR_W = 8,
  parameter int SEQ_W  = 8,
  parameter int IDXW   = $clog2(DEPTH),
  parameter int RANKW  = $clog2(NRANK)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [RANKW-1:0]  wr_rank,
  input  logic              wr_is_wr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SEQ_W-1:0]  wr_seq,
  input  logic [IDXW-1:0]   sel,
  output logic [RANKW-1:0]  sel_rank,
  output logic              sel_is_wr,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [SEQ_W-1:0]  sel_seq,
  output logic              sel_pinned
);
  logic [RANKW-1:0]  q_rank  [DEPTH];
  logic              q_is_wr [DEPTH];
  logic [ADDR_W-1:0] q_addr  [DEPTH];
  logic [SEQ_W-1:0]  q_seq   [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      q_rank[wr_idx]  <= wr_rank;
      q_is_wr[wr_idx] <= wr_is_wr;
      q_addr[wr_idx]  <= wr_addr;
      q_seq[wr_idx]   <= wr_seq;
    end
  end

  assign sel_rank  = q_rank[sel];
  assign sel_is_wr = q_is_wr[sel];
  assign sel_addr  = q_addr[sel];
  assign sel_seq   = q_seq[sel];

  // A read is held behind any older write to the same address in its set.
  always_comb begin
    sel_pinned = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((k < int'(sel)) && q_is_wr[k] && (q_addr[k] == q_addr[sel]) &&
          (q_rank[k] == q_rank[sel]))
        sel_pinned = 1'b1;
    end
    if (q_is_wr[sel]) sel_pinned = 1'b0;
  end
endmodule

// File: rtl/rcq_tally.sv
module rcq_tally #(
  parameter int DEPTH = 16,
  parameter int NRANK = 4,
  parameter int IDXW  = $clog2(DEPTH),
  parameter int RANKW = $clog2(NRANK),
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  step,
  input  logic [RANKW-1:0]      step_rank,
  input  logic                  step_is_wr,
  input  logic                  step_pinned,
  input  logic [IDXW-1:0]       step_pos,
  input  logic                  latch_base,
  output logic [NRANK*CNTW-1:0] base_flat,
  output logic [NRANK*CNTW-1:0] front_flat,
  output logic [NRANK*CNTW-1:0] reads_flat,
  output logic [NRANK*CNTW-1:0] writes_flat
);
  logic            seen  [NRANK];
  logic [IDXW-1:0] first [NRANK];
  logic [CNTW-1:0] nrd   [NRANK];
  logic [CNTW-1:0] nwr   [NRANK];
  logic [CNTW-1:0] nfr   [NRANK];
  logic [CNTW-1:0] base_c [NRANK];
  logic [CNTW-1:0] base_q [NRANK];

  for (genvar g = 0; g < NRANK; g++) begin : g_rank
    logic hit;
    assign hit = step && (int'(step_rank) == g);

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        seen[g]  <= 1'b0;
        first[g] <= '0;
        nrd[g]   <= '0;
        nwr[g]   <= '0;
        nfr[g]   <= '0;
      end else if (hit) begin
        if (step_is_wr) begin
          nwr[g] <= nwr[g] + 1'b1;
        end else begin
          nrd[g] <= nrd[g] + 1'b1;
          if (!step_pinned) nfr[g] <= nfr[g] + 1'b1;
        end
        if (!seen[g]) begin
          seen[g]  <= 1'b1;
          first[g] <= step_pos;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)             base_q[g] <= '0;
      else if (latch_base) base_q[g] <= base_c[g];
    end

    assign base_flat[g*CNTW +: CNTW]   = base_q[g];
    assign front_flat[g*CNTW +: CNTW]  = nfr[g];
    assign reads_flat[g*CNTW +: CNTW]  = nrd[g];
    assign writes_flat[g*CNTW +: CNTW] = nwr[g];
  end

  // A set starts after every set whose rank showed up earlier.
  always_comb begin
    for (int r = 0; r < NRANK; r++) begin
      base_c[r] = '0;
      for (int q = 0; q < NRANK; q++) begin
        if ((q != r) && seen[q] && (first[q] < first[r]))
          base_c[r] = base_c[r] + nrd[q] + nwr[q];
      end
    end
  end
endmodule

// File: rtl/rcq_place.sv
module rcq_place #(
  parameter int DEPTH  = 16,
  parameter int NRANK  = 4,
  parameter int ADDR_W = 8,
  parameter int SEQ_W  = 8,
  parameter int IDXW   = $clog2(DEPTH),
  parameter int RANKW  = $clog2(NRANK),
  parameter int CNTW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  step,
  input  logic [RANKW-1:0]      step_rank,
  input  logic                  step_is_wr,
  input  logic                  step_pinned,
  input  logic [ADDR_W-1:0]     step_addr,
  input  logic [SEQ_W-1:0]      step_seq,
  input  logic [NRANK*CNTW-1:0] base_flat,
  input  logic [NRANK*CNTW-1:0] front_flat,
  input  logic [IDXW-1:0]       rd_idx,
  output logic [RANKW-1:0]      rd_rank,
  output logic                  rd_is_wr,
  output logic [ADDR_W-1:0]     rd_addr,
  output logic [SEQ_W-1:0]      rd_seq
);
  localparam int WORD_W = RANKW + 1 + ADDR_W + SEQ_W;

  logic [CNTW-1:0]   base_a  [NRANK];
  logic [CNTW-1:0]   front_a [NRANK];
  logic [CNTW-1:0]   fcur    [NRANK];
  logic [CNTW-1:0]   tcur    [NRANK];
  logic              to_front;
  logic [CNTW-1:0]   offset;
  logic [IDXW-1:0]   dest;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_word;

  for (genvar g = 0; g < NRANK; g++) begin : g_cur
    assign base_a[g]  = base_flat[g*CNTW +: CNTW];
    assign front_a[g] = front_flat[g*CNTW +: CNTW];

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        fcur[g] <= '0;
        tcur[g] <= '0;
      end else if (step && (int'(step_rank) == g)) begin
        if (to_front) fcur[g] <= fcur[g] + 1'b1;
        else          tcur[g] <= tcur[g] + 1'b1;
      end
    end
  end

  assign to_front = !step_is_wr && !step_pinned;
  assign offset   = to_front ? fcur[step_rank]
                             : front_a[step_rank] + tcur[step_rank];
  assign dest     = IDXW'(base_a[step_rank] + offset);

  always_ff @(posedge clk) begin
    if (step) mem[dest] <= {step_rank, step_is_wr, step_addr, step_seq};
  end

  always_ff @(posedge clk) begin
    rd_word <= mem[rd_idx];
  end

  assign {rd_rank, rd_is_wr, rd_addr, rd_seq} = rd_word;
endmodule

// File: rtl/rank_cluster_reorder.sv
module rank_cluster_reorder #(
  parameter int DEPTH  = 16,
  parameter int NRANK  = 4,
  parameter int ADDR_W = 8,
  parameter int SEQ_W  = 8,
  parameter int IDXW   = $clog2(DEPTH),
  parameter int RANKW  = $clog2(NRANK),
  parameter int CNTW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_en,
  input  logic [IDXW-1:0]       ld_idx,
  input  logic [RANKW-1:0]      ld_rank,
  input  logic                  ld_is_wr,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  logic [SEQ_W-1:0]      ld_seq,
  input  logic [CNTW-1:0]       num_cmds,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  input  logic [IDXW-1:0]       rd_idx,
  output logic [RANKW-1:0]      rd_rank,
  output logic                  rd_is_wr,
  output logic [ADDR_W-1:0]     rd_addr,
  output logic [SEQ_W-1:0]      rd_seq,
  output logic [NRANK*CNTW-1:0] set_reads,
  output logic [NRANK*CNTW-1:0] set_writes
);
  import rcq_pkg::*;

  rcq_phase_e        phase;
  logic [CNTW-1:0]   idx;
  logic [CNTW-1:0]   n_q;
  logic              idle;
  logic              go;
  logic              at_end;
  logic              scan_step;
  logic              place_step;
  logic [RANKW-1:0]  e_rank;
  logic              e_is_wr;
  logic [ADDR_W-1:0] e_addr;
  logic [SEQ_W-1:0]  e_seq;
  logic              e_pinned;
  logic [NRANK*CNTW-1:0] base_flat;
  logic [NRANK*CNTW-1:0] front_flat;

  assign idle       = (phase == PH_IDLE) || (phase == PH_DONE);
  assign go         = start && idle;
  assign at_end     = (idx == n_q);
  assign scan_step  = (phase == PH_SCAN) && !at_end;
  assign place_step = (phase == PH_PLACE) && !at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      idx   <= '0;
      n_q   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (go) begin
      phase <= PH_SCAN;
      idx   <= '0;
      n_q   <= (num_cmds > CNTW'(DEPTH)) ? CNTW'(DEPTH) : num_cmds;
      busy  <= 1'b1;
      done  <= 1'b0;
    end else begin
      unique case (phase)
        PH_SCAN: begin
          if (at_end) begin
            phase <= PH_BASE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_BASE: phase <= PH_PLACE;
        PH_PLACE: begin
          if (at_end) begin
            phase <= PH_DONE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  rcq_src_store #(
    .DEPTH(DEPTH), .NRANK(NRANK), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W),
    .IDXW(IDXW), .RANKW(RANKW)
  ) u_store (
    .clk       (clk),
    .wr_en     (ld_en && idle),
    .wr_idx    (ld_idx),
    .wr_rank   (ld_rank),
    .wr_is_wr  (ld_is_wr),
    .wr_addr   (ld_addr),
    .wr_seq    (ld_seq),
    .sel       (idx[IDXW-1:0]),
    .sel_rank  (e_rank),
    .sel_is_wr (e_is_wr),
    .sel_addr  (e_addr),
    .sel_seq   (e_seq),
    .sel_pinned(e_pinned)
  );

  rcq_tally #(
    .DEPTH(DEPTH), .NRANK(NRANK), .IDXW(IDXW), .RANKW(RANKW), .CNTW(CNTW)
  ) u_tally (
    .clk        (clk),
    .rst        (rst),
    .clear      (go),
    .step       (scan_step),
    .step_rank  (e_rank),
    .step_is_wr (e_is_wr),
    .step_pinned(e_pinned),
    .step_pos   (idx[IDXW-1:0]),
    .latch_base (phase == PH_BASE),
    .base_flat  (base_flat),
    .front_flat (front_flat),
    .reads_flat (set_reads),
    .writes_flat(set_writes)
  );

  rcq_place #(
    .DEPTH(DEPTH), .NRANK(NRANK), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W),
    .IDXW(IDXW), .RANKW(RANKW), .CNTW(CNTW)
  ) u_place (
    .clk        (clk),
    .rst        (rst),
    .clear      (go),
    .step       (place_step),
    .step_rank  (e_rank),
    .step_is_wr (e_is_wr),
    .step_pinned(e_pinned),
    .step_addr  (e_addr),
    .step_seq   (e_seq),
    .base_flat  (base_flat),
    .front_flat (front_flat),
    .rd_idx     (rd_idx),
    .rd_rank    (rd_rank),
    .rd_is_wr   (rd_is_wr),
    .rd_addr    (rd_addr),
    .rd_seq     (rd_seq)
  );
endmodule

// File: rtl/rcq_checker.sv
module rcq_checker #(
  parameter int DEPTH = 16,
  parameter int NRANK = 4,
  parameter int RANKW = $clog2(NRANK),
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic [NRANK*CNTW-1:0] set_reads,
  input logic [NRANK*CNTW-1:0] set_writes,
  input logic [CNTW-1:0]       n_q
);
  localparam int SUMW = CNTW + RANKW + 1;
  logic [SUMW-1:0] tally_sum;

  always_comb begin
    tally_sum = '0;
    for (int r = 0; r < NRANK; r++)
      tally_sum = tally_sum + SUMW'(set_reads[r*CNTW +: CNTW])
                            + SUMW'(set_writes[r*CNTW +: CNTW]);
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!busy && !done)); // R1
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst) !(busy && done)); // R2
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done)); // R2
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R2
  AST_COUNTS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> ($stable(set_reads) && $stable(set_writes))); // R7
  AST_TALLY_TOTAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (tally_sum == SUMW'(n_q))); // R7
  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (rst)
    busy |-> (n_q <= CNTW'(DEPTH))); // R9
endmodule

bind rank_cluster_reorder rcq_checker #(
  .DEPTH(DEPTH), .NRANK(NRANK), .RANKW(RANKW), .CNTW(CNTW)
) u_rcq_checker (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .set_reads (set_reads),
  .set_writes(set_writes),
  .n_q       (n_q)
);

// File: tb/rank_cluster_reorder_bench.sv
module rank_cluster_reorder_bench;
  localparam int DEPTH  = 16;
  localparam int NRANK  = 4;
  localparam int ADDR_W = 8;
  localparam int SEQ_W  = 8;
  localparam int IDXW   = $clog2(DEPTH);
  localparam int RANKW  = $clog2(NRANK);
  localparam int CNTW   = $clog2(DEPTH + 1);

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  ld_en = 1'b0;
  logic [IDXW-1:0]       ld_idx = '0;
  logic [RANKW-1:0]      ld_rank = '0;
  logic                  ld_is_wr = 1'b0;
  logic [ADDR_W-1:0]     ld_addr = '0;
  logic [SEQ_W-1:0]      ld_seq = '0;
  logic [CNTW-1:0]       num_cmds = '0;
  logic                  start = 1'b0;
  logic                  busy;
  logic                  done;
  logic [IDXW-1:0]       rd_idx = '0;
  logic [RANKW-1:0]      rd_rank;
  logic                  rd_is_wr;
  logic [ADDR_W-1:0]     rd_addr;
  logic [SEQ_W-1:0]      rd_seq;
  logic [NRANK*CNTW-1:0] set_reads;
  logic [NRANK*CNTW-1:0] set_writes;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  int b_rank [DEPTH];
  bit b_wr   [DEPTH];
  int b_addr [DEPTH];
  int o_rank [DEPTH];
  bit o_wr   [DEPTH];
  int o_addr [DEPTH];
  int o_seq  [DEPTH];
  int x_idx  [DEPTH];
  int x_order[NRANK];
  int x_nset;

  always #5 clk = ~clk;

  rank_cluster_reorder #(
    .DEPTH(DEPTH), .NRANK(NRANK), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
  ) u_rank_cluster_reorder (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_rank(ld_rank),
    .ld_is_wr(ld_is_wr), .ld_addr(ld_addr), .ld_seq(ld_seq), .num_cmds(num_cmds),
    .start(start), .busy(busy), .done(done), .rd_idx(rd_idx), .rd_rank(rd_rank),
    .rd_is_wr(rd_is_wr), .rd_addr(rd_addr), .rd_seq(rd_seq),
    .set_reads(set_reads), .set_writes(set_writes)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit held(input int j);
    held = 1'b0;
    if (!b_wr[j])
      for (int k = 0; k < j; k++)
        if (b_wr[k] && b_addr[k] == b_addr[j] && b_rank[k] == b_rank[j]) held = 1'b1;
  endfunction

  // Expected sequence from the requirements: set order by first arrival,
  // free reads first, then the rest, both in arrival order.
  function automatic void model(input int n);
    bit got [NRANK];
    int p = 0;
    x_nset = 0;
    for (int r = 0; r < NRANK; r++) got[r] = 1'b0;
    for (int j = 0; j < n; j++)
      if (!got[b_rank[j]]) begin
        got[b_rank[j]] = 1'b1;
        x_order[x_nset] = b_rank[j];
        x_nset++;
      end
    for (int s = 0; s < x_nset; s++) begin
      for (int j = 0; j < n; j++)
        if (b_rank[j] == x_order[s] && !b_wr[j] && !held(j)) begin x_idx[p] = j; p++; end
      for (int j = 0; j < n; j++)
        if (b_rank[j] == x_order[s] && (b_wr[j] || held(j))) begin x_idx[p] = j; p++; end
    end
  endfunction

  task automatic load_all(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = IDXW'(j); ld_rank = RANKW'(b_rank[j]);
      ld_is_wr = b_wr[j]; ld_addr = ADDR_W'(b_addr[j]); ld_seq = SEQ_W'(j);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic launch(input int ncmd, input bit disturb);
    int w;
    @(negedge clk);
    num_cmds = CNTW'(ncmd); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R2", "busy/done after start", {busy, done}, 2);
    if (disturb) begin
      // R8: overwrite slot 0 and restart while busy; both must be dropped
      ld_en = 1'b1; ld_idx = '0; ld_rank = RANKW'(b_rank[0] + 1);
      ld_is_wr = !b_wr[0]; ld_addr = 8'hFF; ld_seq = 8'hEE; start = 1'b1;
      num_cmds = '0;
      @(negedge clk);
      ld_en = 1'b0; start = 1'b0;
    end
    w = 0;
    while (!done && w < 1000) begin @(negedge clk); w++; end
    chk(done && !busy, "R2", "done after run", {busy, done}, 1);
    repeat (3) @(negedge clk);
    chk(done && !busy, "R2", "done held without start", {busy, done}, 1);
  endtask

  task automatic read_out(input int n);
    for (int p = 0; p < n; p++) begin
      @(negedge clk); rd_idx = IDXW'(p);
      @(negedge clk);
      o_rank[p] = int'(rd_rank); o_wr[p] = rd_is_wr;
      o_addr[p] = int'(rd_addr); o_seq[p] = int'(rd_seq);
    end
    if (n > 1) begin
      // R10: a new rd_idx must not show before the next clock edge
      rd_idx = IDXW'(0);
      #1;
      chk(int'(rd_seq) == o_seq[n-1], "R10", "read port latency", int'(rd_seq), o_seq[n-1]);
    end
  endtask

  task automatic verify(input int n, input string tag);
    int mism, a_s, e_s, viol, dup, k;
    bit seen_r [NRANK];
    int cnt_r, cnt_w;
    model(n);
    read_out(n);
    mism = 0; a_s = 0; e_s = 0;
    for (int p = 0; p < n; p++) begin
      int j = x_idx[p];
      if (o_seq[p] != j || o_rank[p] != b_rank[j] || o_wr[p] != b_wr[j] ||
          o_addr[p] != b_addr[j]) begin
        if (mism == 0) begin a_s = o_seq[p]; e_s = j; end
        mism++;
      end
    end
    chk(mism == 0, "R5", {tag, " slot sequence"}, a_s, e_s);
    viol = 0;
    for (int r = 0; r < NRANK; r++) seen_r[r] = 1'b0;
    for (int p = 0; p < n; p++) begin
      if (p > 0 && o_rank[p] != o_rank[p-1] && seen_r[o_rank[p]]) viol++;
      seen_r[o_rank[p]] = 1'b1;
    end
    chk(viol == 0, "R3", {tag, " split rank sets"}, viol, 0);
    viol = 0; k = 0;
    for (int p = 0; p < n; p++)
      if (p == 0 || o_rank[p] != o_rank[p-1]) begin
        if (k >= x_nset || o_rank[p] != x_order[k]) viol++;
        k++;
      end
    chk(viol == 0 && k == x_nset, "R4", {tag, " set order"}, k, x_nset);
    viol = 0;
    for (int p = 0; p < n; p++)
      if (!o_wr[p])
        for (int q = p + 1; q < n; q++)
          if (o_wr[q] && o_addr[q] == o_addr[p] && o_seq[q] < o_seq[p]) viol++;
    chk(viol == 0, "R6", {tag, " read ahead of older write"}, viol, 0);
    dup = 0;
    for (int j = 0; j < n; j++) begin
      int c = 0;
      for (int p = 0; p < n; p++) if (o_seq[p] == j) c++;
      if (c != 1) dup++;
    end
    chk(dup == 0, "R11", {tag, " entries lost or repeated"}, dup, 0);
    for (int r = 0; r < NRANK; r++) begin
      cnt_r = 0; cnt_w = 0;
      for (int j = 0; j < n; j++)
        if (b_rank[j] == r) begin if (b_wr[j]) cnt_w++; else cnt_r++; end
      chk(int'(set_reads[r*CNTW +: CNTW]) == cnt_r, "R7", {tag, " read count"},
          int'(set_reads[r*CNTW +: CNTW]), cnt_r);
      chk(int'(set_writes[r*CNTW +: CNTW]) == cnt_w, "R7", {tag, " write count"},
          int'(set_writes[r*CNTW +: CNTW]), cnt_w);
    end
  endtask

  task automatic put(input int j, input int rank, input bit wr, input int addr);
    b_rank[j] = rank; b_wr[j] = wr; b_addr[j] = addr;
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int seed_dummy;
    seed_dummy = $urandom(32'd424242);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(set_reads == '0 && set_writes == '0, "R1", "counts after reset",
        int'(set_reads), 0);

    // Four ranks: set0 1R/4W, set1 1W, set2 1R/1W, set3 empty
    put(0, 0, 1, 0*4+0); put(1, 1, 1, 1*4+1); put(2, 2, 0, 2*4+2); put(3, 0, 1, 3*4+0);
    put(4, 2, 1, 4*4+2); put(5, 0, 0, 5*4+0); put(6, 0, 1, 6*4+0); put(7, 0, 1, 7*4+0);
    load_all(8);
    launch(8, 1'b0);
    verify(8, "four-rank");
    chk(set_reads[0 +: CNTW] == 1 && set_writes[0 +: CNTW] == 4 &&
        set_writes[CNTW +: CNTW] == 1 && set_reads[CNTW +: CNTW] == 0 &&
        set_reads[3*CNTW +: CNTW] == 0 && set_writes[3*CNTW +: CNTW] == 0,
        "R7", "four-rank fixed counts", int'(set_writes[0 +: CNTW]), 4);

    // Hazard chain on rank 1: W5, R9, R5 (held), W9
    put(0, 1, 1, 5); put(1, 1, 0, 9); put(2, 1, 0, 5); put(3, 1, 1, 9);
    put(4, 3, 0, 7); put(5, 1, 0, 13);
    load_all(6);
    launch(6, 1'b0);
    verify(6, "hazard");

    // Loads and start while busy are dropped (R8)
    for (int j = 0; j < 10; j++) put(j, j % NRANK, j[0], (j % 3) * NRANK + (j % NRANK));
    load_all(10);
    launch(10, 1'b1);
    verify(10, "R8 busy-loads");

    // Empty run (R9)
    launch(0, 1'b0);
    chk(set_reads == '0 && set_writes == '0, "R9", "empty run counts", int'(set_writes), 0);

    // Over-length count is clamped (R9)
    for (int j = 0; j < DEPTH; j++) begin
      int r = int'($urandom % NRANK);
      put(j, r, bit'($urandom % 2), int'($urandom % 3) * NRANK + r);
    end
    load_all(DEPTH);
    launch(DEPTH + 3, 1'b0);
    verify(DEPTH, "R9 clamp");

    // Random queues, dense in same-address pairs
    for (int t = 0; t < 40; t++) begin
      int n = 1 + int'($urandom % DEPTH);
      int nr = 1 + int'($urandom % NRANK);
      for (int j = 0; j < n; j++) begin
        int r = int'($urandom % nr);
        put(j, r, bit'($urandom % 2), int'($urandom % 3) * NRANK + r);
      end
      load_all(n);
      launch(n, bit'(t % 5 == 0));
      verify(n, "random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule